// File: doc/BRIEF.md
# Two-Stage Bark/Bite Watchdog Timer

This block is a watchdog counter for a processor subsystem. A slow-clock tick enable, nominally 32768 pulses per second, advances the count, so software writes both thresholds in units of those ticks. The count is compared against two programmable limits. The lower limit (bark) raises a level interrupt so that software can log state. The higher limit (bite) asks for a chip-wide reset. The bite request only leaves the block while an external reset-routing configuration bit is held high.

Software controls the block over a small 32-bit register bus with a single-cycle write strobe and a combinational read path. A pet write restarts the count. An enable register starts and stops the count. The two threshold registers can be rewritten while the count runs. A typical driver programs a bark limit of 8 s and a bite limit of 10 s, enables the count, and pets it well inside the bark window. Around a suspend it turns the count off, and on resume it turns the count back on and then pets it. The bark and bite flags are sticky. Only a pet, a disable or a block reset clears them.

Top module: `wdog_bark_bite`

## Requirements
- R1: After reset the enable bit, the count and both thresholds read as zero, and `bark_irq` and `bite_rst_req` are low.
- R2: In a cycle where the block is enabled, `tick` is high and no pet or enable write occurs, the count advances by exactly one. In every other cycle the count holds.
- R3: A write to offset 0x38 with bit 0 set clears the count and both flags. A tick in the same cycle is ignored. A write there with bit 0 clear has no effect.
- R4: A write to offset 0x40 stores bit 0 as the enable. Storing 0 stops the count without clearing it, and clears both flags. While the block is disabled, neither flag can set.
- R5: On an enabled tick whose new count is greater than or equal to the bark threshold, the bark flag sets. `bark_irq` then stays high until a pet or a disable.
- R6: The bite flag sets in the same way against the bite threshold. `bite_rst_req` is the bite flag ANDed with the `route_bite` input, so a low `route_bite` blocks the request and raising it later releases a flag that is already set.
- R7: The thresholds at offsets 0x4C (bark) and 0x5C (bite) may be rewritten while the count runs. A new value is only compared on the next enabled tick. A value lowered below the current count fires on that tick.
- R8: Reads are combinational. Offset 0x38 returns the count, 0x40 returns the enable in bit 0, and 0x4C and 0x5C return the thresholds. Threshold writes keep only the low CW bits, and all unused bits read as zero. Unmapped offsets read as zero and ignore writes.
- R9: With saturation selected, the default, the count stops at its all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Slow-clock tick enable, one clk cycle wide |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | AW | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| route_bite | input | 1 | Reset-routing configuration bit; 1 lets the bite through |
| bark_irq | output | 1 | Sticky level interrupt at the first threshold |
| bite_rst_req | output | 1 | Gated chip-reset request at the second threshold |

## Verification
A wrong count shows up on the next read of offset 0x38. It also moves the tick on which the flags rise, by as many ticks as the count is off. A flag that fails to clear, or that sets while disabled, shows up on the output pins within one clock of the pet, the disable or the offending tick. A lost enable or threshold bit shows up at once on a read of its offset, and again on the first comparison that uses it. The bench compares every register and both pins against a reference model after each operation, so such a fault is reported within a few cycles.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // Byte offsets of the software-visible registers.
   localparam int unsigned OFS_PET   = 32'h38;
   localparam int unsigned OFS_EN    = 32'h40;
   localparam int unsigned OFS_BARK  = 32'h4C;
   localparam int unsigned OFS_BITE  = 32'h5C;

   // Comparator stages: index 0 raises the interrupt, index 1 the reset.
   localparam int unsigned NUM_STAGES = 2;
   localparam int unsigned STG_BARK   = 0;
   localparam int unsigned STG_BITE   = 1;

   // Decoded write strobes for one bus cycle.
   typedef struct packed {
      logic pet;     // restart request (bit 0 set)
      logic en_wr;   // any write to the enable register
      logic en_val;  // value written to the enable bit
   } wdog_ctl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
   import wdog_pkg::*;
#(
   parameter int unsigned CW = 32,
   parameter int unsigned AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   input  logic [CW-1:0] cnt,
   output logic          en,
   output logic [CW-1:0] bark_thr,
   output logic [CW-1:0] bite_thr,
   output wdog_ctl_t     ctl,
   output logic [31:0]   bus_rdata
);
   logic hit_pet, hit_en, hit_bark, hit_bite;

   assign hit_pet  = (bus_addr == AW'(OFS_PET));
   assign hit_en   = (bus_addr == AW'(OFS_EN));
   assign hit_bark = (bus_addr == AW'(OFS_BARK));
   assign hit_bite = (bus_addr == AW'(OFS_BITE));

   assign ctl.pet    = bus_wr & hit_pet & bus_wdata[0];
   assign ctl.en_wr  = bus_wr & hit_en;
   assign ctl.en_val = bus_wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         bark_thr <= '0;
         bite_thr <= '0;
      end else begin
         if (ctl.en_wr)
            en <= bus_wdata[0];
         if (bus_wr && hit_bark)
            bark_thr <= bus_wdata[CW-1:0];
         if (bus_wr && hit_bite)
            bite_thr <= bus_wdata[CW-1:0];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (hit_pet)
         bus_rdata[CW-1:0] = cnt;
      else if (hit_en)
         bus_rdata[0] = en;
      else if (hit_bark)
         bus_rdata[CW-1:0] = bark_thr;
      else if (hit_bite)
         bus_rdata[CW-1:0] = bite_thr;
   end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int unsigned CW       = 32,
   parameter bit          SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          en,
   input  logic          pet,
   input  logic          en_wr,
   output logic [CW-1:0] cnt,
   output logic [CW-1:0] cnt_nxt,
   output logic          step
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   // Any write to pet or enable takes priority over a tick in the same cycle.
   assign step = en & tick & ~pet & ~en_wr;

   generate
      if (SATURATE) begin : g_sat
         assign cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
      end else begin : g_wrap
         assign cnt_nxt = cnt + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (pet)
         cnt <= '0;
      else if (step)
         cnt <= cnt_nxt;
   end
endmodule

// File: rtl/wdog_stage.sv
module wdog_stage #(
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [CW-1:0] cnt_nxt,
   input  logic [CW-1:0] thr,
   input  logic          clr,
   output logic          flag
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (clr)
         flag <= 1'b0;
      else if (step && (cnt_nxt >= thr))
         flag <= 1'b1;
   end
endmodule

// File: rtl/wdog_bark_bite.sv
module wdog_bark_bite
   import wdog_pkg::*;
#(
   parameter int unsigned CW       = 32,
   parameter int unsigned AW       = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          bus_wr,
   input  logic [AW-1:0] bus_addr,
   input  logic [31:0]   bus_wdata,
   output logic [31:0]   bus_rdata,
   input  logic          route_bite,
   output logic          bark_irq,
   output logic          bite_rst_req
);
   generate
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("wdog_bark_bite: CW must lie in 2..32");
      end
      if (AW < 7 || AW > 32) begin : g_bad_aw
         $error("wdog_bark_bite: AW must lie in 7..32");
      end
   endgenerate

   logic                en;
   logic [CW-1:0]       cnt;
   logic [CW-1:0]       cnt_nxt;
   logic                step;
   logic                clr;
   wdog_ctl_t           ctl;
   logic [CW-1:0]       thr_a [NUM_STAGES];
   logic [NUM_STAGES-1:0] flag;

   wdog_regs #(.CW(CW), .AW(AW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .cnt       (cnt),
      .en        (en),
      .bark_thr  (thr_a[STG_BARK]),
      .bite_thr  (thr_a[STG_BITE]),
      .ctl       (ctl),
      .bus_rdata (bus_rdata)
   );

   wdog_counter #(.CW(CW), .SATURATE(SATURATE)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .en      (en),
      .pet     (ctl.pet),
      .en_wr   (ctl.en_wr),
      .cnt     (cnt),
      .cnt_nxt (cnt_nxt),
      .step    (step)
   );

   // Flags drop on a pet or on a write that turns the count off.
   assign clr = ctl.pet | (ctl.en_wr & ~ctl.en_val);

   for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
      wdog_stage #(.CW(CW)) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .step    (step),
         .cnt_nxt (cnt_nxt),
         .thr     (thr_a[s]),
         .clr     (clr),
         .flag    (flag[s])
      );
   end

   assign bark_irq     = flag[STG_BARK];
   assign bite_rst_req = flag[STG_BITE] & route_bite;
endmodule

// File: rtl/wdog_bark_bite_chk.sv
module wdog_bark_bite_chk
   import wdog_pkg::*;
#(
   parameter int unsigned CW = 32,
   parameter int unsigned AW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick,
   input logic          bus_wr,
   input logic [AW-1:0] bus_addr,
   input logic [31:0]   bus_wdata,
   input logic          route_bite,
   input logic          bark_irq,
   input logic          bite_rst_req,
   input logic          en_q,
   input logic [CW-1:0] cnt_q
);
   localparam logic [CW-1:0] CMAX = '1;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q && tick && !bus_wr && cnt_q != CMAX) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !bus_wr) |=> $stable(cnt_q)); // R2
   AST_PET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFS_PET) && bus_wdata[0]) |=> (cnt_q == '0 && !bark_irq && !bite_rst_req)); // R3
   AST_OFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == AW'(OFS_EN) && !bus_wdata[0]) |=> (!bark_irq && !bite_rst_req)); // R4
   AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !bark_irq) |=> !bark_irq); // R4
   AST_BARK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (bark_irq && !bus_wr) |=> bark_irq); // R5
   AST_BITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !route_bite |-> !bite_rst_req); // R6
   AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CMAX && !bus_wr) |=> (cnt_q == CMAX)); // R9
endmodule

bind wdog_bark_bite wdog_bark_bite_chk #(.CW(CW), .AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick         (tick),
   .bus_wr       (bus_wr),
   .bus_addr     (bus_addr),
   .bus_wdata    (bus_wdata),
   .route_bite   (route_bite),
   .bark_irq     (bark_irq),
   .bite_rst_req (bite_rst_req),
   .en_q         (en),
   .cnt_q        (cnt)
);

// File: tb/tb_wdog_bark_bite.sv
module tb_wdog_bark_bite;
   localparam int unsigned CW   = 12;
   localparam int unsigned AW   = 8;
   localparam int unsigned CMAX = (1 << CW) - 1;
   localparam logic [AW-1:0] A_PET  = 8'h38;
   localparam logic [AW-1:0] A_EN   = 8'h40;
   localparam logic [AW-1:0] A_BARK = 8'h4C;
   localparam logic [AW-1:0] A_BITE = 8'h5C;
   localparam logic [AW-1:0] A_HOLE = 8'h44;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          route_bite = 1'b0;
   logic          bark_irq;
   logic          bite_rst_req;

   always #2 clk = ~clk;

   wdog_bark_bite #(.CW(CW), .AW(AW), .SATURATE(1'b1)) dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (tick),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .route_bite   (route_bite),
      .bark_irq     (bark_irq),
      .bite_rst_req (bite_rst_req)
   );

   int checks = 0;
   int failures = 0;

   // Reference model state
   bit          m_en = 0, m_bark = 0, m_bite = 0, m_route = 0;
   int unsigned m_cnt = 0, m_bthr = 0, m_kthr = 0;

   function automatic int unsigned sat_inc(int unsigned v);
      return (v >= CMAX) ? CMAX : v + 1;
   endfunction

   function automatic int unsigned trim(logic [31:0] d);
      return d & CMAX;
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic step_tick();
      @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      if (m_en) begin
         m_cnt = sat_inc(m_cnt);
         if (m_cnt >= m_bthr) m_bark = 1;
         if (m_cnt >= m_kthr) m_bite = 1;
      end
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) step_tick();
   endtask

   // with_tick is only used for pet and enable writes, which win over a tick.
   task automatic wr(logic [AW-1:0] a, logic [31:0] d, bit with_tick = 0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick = with_tick;
      @(negedge clk);
      bus_wr = 1'b0; tick = 1'b0;
      case (a)
         A_PET:  if (d[0]) begin m_cnt = 0; m_bark = 0; m_bite = 0; end
         A_EN:   begin m_en = d[0]; if (!d[0]) begin m_bark = 0; m_bite = 0; end end
         A_BARK: m_bthr = trim(d);
         A_BITE: m_kthr = trim(d);
         default: ;
      endcase
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_route(bit v);
      @(negedge clk);
      route_bite = v;
      m_route = v;
      #1;
   endtask

   task automatic check_all(string req);
      logic [31:0] d;
      rd(A_PET, d);  chk(req, "count", d, m_cnt);
      rd(A_EN, d);   chk(req, "enable", d, {31'b0, m_en});
      rd(A_BARK, d); chk(req, "bark_thr", d, m_bthr);
      rd(A_BITE, d); chk(req, "bite_thr", d, m_kthr);
      chk(req, "bark_irq", {31'b0, bark_irq}, {31'b0, m_bark});
      chk(req, "bite_rst_req", {31'b0, bite_rst_req}, {31'b0, m_bite & m_route});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R2 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd2024));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_all("R1");

      // R2: count advances only while enabled (thresholds 0 fire at once)
      wr(A_EN, 32'h1);
      ticks(3);
      check_all("R2");
      // R4: disable clears flags, stops the count, and blocks firing
      wr(A_EN, 32'h0);
      check_all("R4");
      ticks(2);
      check_all("R4");

      // R3: pet with bit 0 clear does nothing; pet with a tick wins
      wr(A_PET, 32'h0);
      check_all("R3");
      wr(A_EN, 32'h1);
      wr(A_PET, 32'h1, 1'b1);
      check_all("R3");

      // R5 and R6: bark at 5, bite at 8
      wr(A_BARK, 32'd5);
      wr(A_BITE, 32'd8);
      set_route(1'b1);
      wr(A_PET, 32'h1);
      ticks(4);
      check_all("R5");
      step_tick();
      check_all("R5");
      ticks(2);
      check_all("R6");
      step_tick();
      check_all("R6");
      set_route(1'b0);
      check_all("R6");
      set_route(1'b1);
      check_all("R6");
      wr(A_PET, 32'h1);
      check_all("R5");

      // R7: lowering a threshold below the count fires on the next tick only
      wr(A_BARK, 32'd20);
      wr(A_BITE, 32'd30);
      ticks(10);
      wr(A_BARK, 32'd3);
      check_all("R7");
      step_tick();
      check_all("R7");

      // R8: unmapped offset and threshold truncation
      wr(A_HOLE, 32'hFFFF_FFFF);
      rd(A_HOLE, d);
      chk("R8", "hole", d, 32'h0);
      wr(A_BITE, 32'hFFFF_FFFF);
      check_all("R8");

      // R9: saturation at the all-ones count
      wr(A_BARK, CMAX);
      wr(A_PET, 32'h1);
      ticks(CMAX - 1);
      check_all("R9");
      ticks(6);
      check_all("R9");

      // Random mix
      set_route(1'b0);
      wr(A_BARK, 32'd6);
      wr(A_BITE, 32'd12);
      wr(A_PET, 32'h1);
      for (int i = 0; i < 400; i++) begin
         int unsigned op;
         op = $urandom_range(0, 11);
         case (op)
            0, 1, 2, 3, 4, 5: step_tick();
            6: wr(A_PET, {31'b0, 1'($urandom_range(0, 1))});
            7: wr(A_EN, {31'b0, 1'($urandom_range(0, 3) != 0)});
            8: wr(A_BARK, $urandom_range(0, 40));
            9: wr(A_BITE, $urandom_range(0, 60));
            10: set_route(1'($urandom_range(0, 1)));
            default: wr(A_PET, 32'h1, 1'b1);
         endcase
         check_all("R7");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule